// File: doc/BRIEF.md
# Crossbar Master Port Controller

This block is the front end that one bus master sees when it talks into a multi-layer crossbar. It watches the master's address phase: transfer type, address, direction and size. It decodes which of several slave ports the address belongs to, using a parameterised map in which each port has a base and a mask. It then raises a one-hot request toward that port's arbiter. When the arbiter grants in the same cycle, the transfer goes straight through on the live address and control. When it does not, the address phase is frozen in a capture register and the master is wait-stated until the grant arrives. After the grant, completion of the data phase is signalled by passing the slave's ready back to the master.

Two decoders are used. A presence decoder always runs and flags addresses that hit no slave. A select decoder drives a request only when the control state machine allows one. Because of this gating, an access to a second slave waits while a data phase on the first slave is still being wait-stated. Unmapped addresses are never forwarded. They receive a two-cycle error response. A BUSY transfer keeps the current request alive only while the port still holds its grant. Once the grant is lost, the port stays silent until the master issues a sequential or non-sequential transfer again.

Top module: `xbar_master_port`

## Requirements
- R1: After a synchronous reset, m_hready is 1, m_hresp is 0, s_req is all zero and any captured address phase is discarded, so s_haddr follows m_haddr.
- R2: An IDLE transfer (m_htrans = 2'b00) accepted while m_hready is 1 raises no request and completes with m_hready 1 and m_hresp 0.
- R3: An accepted NSEQ (2'b10) or SEQ (2'b11) transfer to a mapped address asserts, in the same cycle, exactly the s_req bit of the matching slave. Slave k matches when (addr & mask_k) == base_k, and the lowest matching index wins. The default map uses mask 0xF000_0000 with bases 0x0000_0000, 0x1000_0000, 0x2000_0000 and 0x4000_0000 for slaves 0 to 3.
- R4: After a transfer is forwarded, m_hready equals s_hready in every cycle of its data phase.
- R5: If no grant is present when a mapped transfer is accepted, its address and control are captured. s_haddr, s_hwrite, s_hsize and s_htrans then come from the capture even if the master changes its outputs. The request to the captured slave is held and m_hready is 0 until the grant is seen.
- R6: While a forwarded data phase has s_hready low, no request is raised. A following access to a different slave gets its request only in the cycle where s_hready is 1.
- R7: An accepted NSEQ/SEQ to an unmapped address raises no request. It is followed by one cycle with m_hready 0 and m_hresp 1, then one cycle with m_hready 1 and m_hresp 1.
- R8: A BUSY transfer (2'b01) keeps the request to the owning slave asserted while that slave's grant is still high.
- R9: If the grant is low during a BUSY transfer, the request is dropped. It stays dropped in later BUSY cycles even if the grant returns, until an NSEQ or SEQ is accepted.
- R10: At most one bit of s_req is set in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_htrans | input | 2 | Master transfer type (IDLE, BUSY, NSEQ, SEQ) |
| m_haddr | input | AW | Master address |
| m_hwrite | input | 1 | Master write flag |
| m_hsize | input | SW | Master transfer size |
| m_hready | output | 1 | Ready returned to the master |
| m_hresp | output | 1 | Error response to the master |
| s_req | output | NS | One-hot request to the slave ports |
| s_gnt | input | NS | Grant from each slave port's arbiter |
| s_hready | input | 1 | Ready of the slave currently serving the port |
| s_htrans | output | 2 | Forwarded transfer type |
| s_haddr | output | AW | Forwarded address (live or captured) |
| s_hwrite | output | 1 | Forwarded write flag |
| s_hsize | output | SW | Forwarded transfer size |

## Verification
Requests, m_hready and the forwarded address respond in the same cycle as the inputs and the current state. A state change caused by an input shows up one edge later. The error pattern follows a hole access by one and then two cycles. The bench changes inputs on the falling edge and samples outputs two nanoseconds later, before the next rising edge. So each check sees the state that the previous edge produced, combined with this cycle's stimulus. The vector table is one row per cycle, so the one- and two-cycle delays of the error, capture and BUSY-lockout paths sit in consecutive rows.

// File: rtl/xmp_pkg.sv
package xmp_pkg;

  localparam logic [1:0] HT_IDLE = 2'b00;
  localparam logic [1:0] HT_BUSY = 2'b01;
  localparam logic [1:0] HT_NSEQ = 2'b10;
  localparam logic [1:0] HT_SEQ  = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_BUSY   = 3'd1,
    ST_WAIT   = 3'd2,
    ST_STALL  = 3'd3,
    ST_STEADY = 3'd4,
    ST_ERR1   = 3'd5,
    ST_ERR2   = 3'd6
  } xmp_state_e;

  function automatic logic is_active(input logic [1:0] t);
    return t[1];
  endfunction

endpackage

// File: rtl/xmp_capture.sv
module xmp_capture #(
  parameter int AW = 32,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    live_trans,
  input  logic [AW-1:0] live_addr,
  input  logic          live_write,
  input  logic [SW-1:0] live_size,
  input  logic          load,
  input  logic          cap_free,
  output logic          cap_valid,
  output logic [1:0]    eff_trans,
  output logic [AW-1:0] eff_addr,
  output logic          eff_write,
  output logic [SW-1:0] eff_size
);

  logic          valid_q;
  logic [1:0]    trans_q;
  logic [AW-1:0] addr_q;
  logic          write_q;
  logic [SW-1:0] size_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
    end else if (load) begin
      valid_q <= 1'b1;
    end else if (cap_free) begin
      valid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      trans_q <= live_trans;
      addr_q  <= live_addr;
      write_q <= live_write;
      size_q  <= live_size;
    end
  end

  assign cap_valid = valid_q;

  always_comb begin
    if (valid_q) begin
      eff_trans = trans_q;
      eff_addr  = addr_q;
      eff_write = write_q;
      eff_size  = size_q;
    end else begin
      eff_trans = live_trans;
      eff_addr  = live_addr;
      eff_write = live_write;
      eff_size  = live_size;
    end
  end

  // R5: a held capture does not move while it waits for its grant
  p_cap_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !cap_free && !load) |=> ($stable(eff_addr) && $stable(eff_write) && cap_valid));

endmodule

// File: rtl/xmp_decode.sv
module xmp_decode #(
  parameter int              AW       = 32,
  parameter int              NS       = 4,
  parameter int              IW       = 2,
  parameter logic [NS*AW-1:0] MAP_BASE = '0,
  parameter logic [NS*AW-1:0] MAP_MASK = '0
) (
  input  logic [AW-1:0] addr,
  input  logic          sel_en,
  output logic          hole,
  output logic [IW-1:0] idx,
  output logic [NS-1:0] sel
);

  logic [NS-1:0] match;

  for (genvar g = 0; g < NS; g++) begin : g_entry
    assign match[g] = ((addr & MAP_MASK[g*AW +: AW]) == MAP_BASE[g*AW +: AW]);
  end

  // presence decoder: always running, lowest index wins
  always_comb begin
    idx = '0;
    for (int i = NS - 1; i >= 0; i--) begin
      if (match[i]) idx = IW'(i);
    end
  end

  assign hole = ~|match;

  // select decoder: gated by the state machine
  assign sel = (sel_en && !hole) ? (NS'(1) << idx) : '0;

endmodule

// File: rtl/xmp_fsm.sv
module xmp_fsm
  import xmp_pkg::*;
#(
  parameter int NS = 4,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    trans,
  input  logic          hole,
  input  logic [IW-1:0] dec_idx,
  input  logic [NS-1:0] s_gnt,
  input  logic          s_hready,
  output logic          sel_en,
  output logic          keep_busy,
  output logic [IW-1:0] own_idx,
  output logic          cap_load,
  output logic          cap_release,
  output logic          m_hready,
  output logic          m_hresp,
  output logic          dphase
);

  xmp_state_e    state_q, state_d;
  logic          own_vld_q, own_vld_d;
  logic [IW-1:0] own_idx_q, own_idx_d;
  logic          lock_q, lock_d;
  logic          acc;
  logic          active;

  assign active = is_active(trans);
  assign acc    = (state_q == ST_IDLE) || (state_q == ST_BUSY) || (state_q == ST_ERR2) ||
                  (((state_q == ST_STEADY) || (state_q == ST_STALL)) && s_hready);

  always_comb begin
    state_d     = state_q;
    own_vld_d   = own_vld_q && s_gnt[own_idx_q];
    own_idx_d   = own_idx_q;
    lock_d      = lock_q;
    sel_en      = 1'b0;
    keep_busy   = 1'b0;
    cap_load    = 1'b0;
    cap_release = 1'b0;

    case (state_q)
      ST_WAIT: begin
        sel_en = 1'b1;
        if (s_gnt[dec_idx]) begin
          state_d     = ST_STEADY;
          cap_release = 1'b1;
          own_vld_d   = 1'b1;
          own_idx_d   = dec_idx;
        end
      end
      ST_ERR1: state_d = ST_ERR2;
      ST_STEADY: begin
        if (!s_hready && active && !hole && (dec_idx != own_idx_q)) state_d = ST_STALL;
      end
      default: ;
    endcase

    if (acc) begin
      if (active) begin
        lock_d = 1'b0;
        if (hole) begin
          state_d = ST_ERR1;
        end else begin
          sel_en = 1'b1;
          if (s_gnt[dec_idx]) begin
            state_d   = ST_STEADY;
            own_vld_d = 1'b1;
            own_idx_d = dec_idx;
          end else begin
            cap_load = 1'b1;
            state_d  = ST_WAIT;
          end
        end
      end else if (trans == HT_BUSY) begin
        state_d = ST_BUSY;
        if (own_vld_q && s_gnt[own_idx_q] && !lock_q) keep_busy = 1'b1;
        else lock_d = 1'b1;
      end else begin
        state_d = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      own_vld_q <= 1'b0;
      own_idx_q <= '0;
      lock_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      own_vld_q <= own_vld_d;
      own_idx_q <= own_idx_d;
      lock_q    <= lock_d;
    end
  end

  always_comb begin
    case (state_q)
      ST_WAIT, ST_ERR1:      m_hready = 1'b0;
      ST_STEADY, ST_STALL:   m_hready = s_hready;
      default:               m_hready = 1'b1;
    endcase
  end

  assign m_hresp = (state_q == ST_ERR1) || (state_q == ST_ERR2);
  assign dphase  = (state_q == ST_STEADY) || (state_q == ST_STALL);
  assign own_idx = own_idx_q;

  // R7: an accepted hole access opens the error pair on the next cycle
  p_hole_err_r7: assert property (@(posedge clk) disable iff (rst)
    (acc && active && hole) |=> (m_hresp && !m_hready));

  // R5: a capture wait-states the master and keeps requesting
  p_cap_wait_r5: assert property (@(posedge clk) disable iff (rst)
    cap_load |=> (!m_hready && sel_en));

  // R9: after the grant was lost, BUSY never revives the request
  p_busy_lock_r9: assert property (@(posedge clk) disable iff (rst)
    (acc && (trans == HT_BUSY) && !keep_busy) |=> !(acc && (trans == HT_BUSY) && keep_busy));

endmodule

// File: rtl/xbar_master_port.sv
module xbar_master_port #(
  parameter int               AW       = 32,
  parameter int               SW       = 3,
  parameter int               NS       = 4,
  parameter logic [NS*AW-1:0] MAP_BASE = {32'h4000_0000, 32'h2000_0000, 32'h1000_0000, 32'h0000_0000},
  parameter logic [NS*AW-1:0] MAP_MASK = {4{32'hF000_0000}}
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    m_htrans,
  input  logic [AW-1:0] m_haddr,
  input  logic          m_hwrite,
  input  logic [SW-1:0] m_hsize,
  output logic          m_hready,
  output logic          m_hresp,
  output logic [NS-1:0] s_req,
  input  logic [NS-1:0] s_gnt,
  input  logic          s_hready,
  output logic [1:0]    s_htrans,
  output logic [AW-1:0] s_haddr,
  output logic          s_hwrite,
  output logic [SW-1:0] s_hsize
);

  localparam int IW = (NS > 1) ? $clog2(NS) : 1;

  logic          cap_valid;
  logic [1:0]    eff_trans;
  logic [AW-1:0] eff_addr;
  logic          eff_write;
  logic [SW-1:0] eff_size;
  logic          hole;
  logic [IW-1:0] dec_idx;
  logic [NS-1:0] dec_sel;
  logic          sel_en;
  logic          keep_busy;
  logic [IW-1:0] own_idx;
  logic          cap_load;
  logic          cap_release;
  logic          dphase;

  xmp_capture #(.AW(AW), .SW(SW)) u_cap (
    .clk        (clk),
    .rst        (rst),
    .live_trans (m_htrans),
    .live_addr  (m_haddr),
    .live_write (m_hwrite),
    .live_size  (m_hsize),
    .load       (cap_load),
    .cap_free   (cap_release),
    .cap_valid  (cap_valid),
    .eff_trans  (eff_trans),
    .eff_addr   (eff_addr),
    .eff_write  (eff_write),
    .eff_size   (eff_size)
  );

  xmp_decode #(.AW(AW), .NS(NS), .IW(IW), .MAP_BASE(MAP_BASE), .MAP_MASK(MAP_MASK)) u_dec (
    .addr   (eff_addr),
    .sel_en (sel_en),
    .hole   (hole),
    .idx    (dec_idx),
    .sel    (dec_sel)
  );

  xmp_fsm #(.NS(NS), .IW(IW)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .trans       (eff_trans),
    .hole        (hole),
    .dec_idx     (dec_idx),
    .s_gnt       (s_gnt),
    .s_hready    (s_hready),
    .sel_en      (sel_en),
    .keep_busy   (keep_busy),
    .own_idx     (own_idx),
    .cap_load    (cap_load),
    .cap_release (cap_release),
    .m_hready    (m_hready),
    .m_hresp     (m_hresp),
    .dphase      (dphase)
  );

  assign s_req    = dec_sel | (keep_busy ? (NS'(1) << own_idx) : '0);
  assign s_htrans = eff_trans;
  assign s_haddr  = eff_addr;
  assign s_hwrite = eff_write;
  assign s_hsize  = eff_size;

  // R10: never two slaves requested at once
  p_req_onehot_r10: assert property (@(posedge clk) disable iff (rst) $onehot0(s_req));

  // R7: first error cycle is always followed by the second
  p_err_pair_r7: assert property (@(posedge clk) disable iff (rst)
    (m_hresp && !m_hready) |=> (m_hresp && m_hready));

  // R6: no request while the running data phase is wait-stated
  p_stall_noreq_r6: assert property (@(posedge clk) disable iff (rst)
    (dphase && !s_hready) |-> (s_req == '0));

  // R3: a permitted mapped access requests its decoded slave
  p_req_target_r3: assert property (@(posedge clk) disable iff (rst)
    (sel_en && !hole) |-> (s_req[dec_idx] && ($countones(s_req) == 1)));

  // R5: while a capture is held, the forwarded control is the captured copy
  p_cap_mux_r5: assert property (@(posedge clk) disable iff (rst)
    (cap_valid && $stable(cap_valid)) |-> $stable(s_haddr));

endmodule

// File: tb/xbar_master_port_tb.sv
module xbar_master_port_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  m_htrans = 2'b00;
  logic [31:0] m_haddr = '0;
  logic        m_hwrite = 1'b0;
  logic [2:0]  m_hsize = 3'd2;
  logic        m_hready;
  logic        m_hresp;
  logic [3:0]  s_req;
  logic [3:0]  s_gnt = '0;
  logic        s_hready = 1'b1;
  logic [1:0]  s_htrans;
  logic [31:0] s_haddr;
  logic        s_hwrite;
  logic [2:0]  s_hsize;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  xbar_master_port u_dut (
    .clk(clk), .rst(rst), .m_htrans(m_htrans), .m_haddr(m_haddr), .m_hwrite(m_hwrite),
    .m_hsize(m_hsize), .m_hready(m_hready), .m_hresp(m_hresp), .s_req(s_req),
    .s_gnt(s_gnt), .s_hready(s_hready), .s_htrans(s_htrans), .s_haddr(s_haddr),
    .s_hwrite(s_hwrite), .s_hsize(s_hsize)
  );

  localparam logic [31:0] A0 = 32'h0000_0010;
  localparam logic [31:0] A1 = 32'h1000_0020;
  localparam logic [31:0] A2 = 32'h2000_0000;
  localparam logic [31:0] A3 = 32'h4000_0000;
  localparam logic [31:0] H1 = 32'h3000_0000;
  localparam logic [31:0] H2 = 32'h8000_0000;

  // {trans, addr, gnt, s_hready, exp_req, exp_rdy, exp_rsp, req_tag}
  localparam int NV = 22;
  localparam logic [48:0] VEC [NV] = '{
    {2'd0, A0, 4'b0000, 1'b1, 4'b0000, 1'b1, 1'b0, 4'd2},  // R2 idle, no request
    {2'd2, A1, 4'b0010, 1'b1, 4'b0010, 1'b1, 1'b0, 4'd3},  // R3 slave 1 forwarded
    {2'd2, A2, 4'b0010, 1'b0, 4'b0000, 1'b0, 1'b0, 4'd6},  // R6 waited, slave 2 held off
    {2'd2, A2, 4'b0010, 1'b0, 4'b0000, 1'b0, 1'b0, 4'd6},  // R6 still stalled
    {2'd2, A2, 4'b0100, 1'b1, 4'b0100, 1'b1, 1'b0, 4'd6},  // R6 released on ready
    {2'd2, H1, 4'b0100, 1'b1, 4'b0000, 1'b1, 1'b0, 4'd7},  // R7 hole, no request
    {2'd2, H1, 4'b0000, 1'b1, 4'b0000, 1'b0, 1'b1, 4'd7},  // R7 first error cycle
    {2'd0, A0, 4'b0000, 1'b1, 4'b0000, 1'b1, 1'b1, 4'd7},  // R7 second error cycle
    {2'd2, A0, 4'b0000, 1'b1, 4'b0001, 1'b1, 1'b0, 4'd5},  // R5 no grant, captured
    {2'd2, A3, 4'b0000, 1'b1, 4'b0001, 1'b0, 1'b0, 4'd5},  // R5 waiting on capture
    {2'd2, A3, 4'b0001, 1'b1, 4'b0001, 1'b0, 1'b0, 4'd5},  // R5 grant arrives
    {2'd2, A3, 4'b0001, 1'b1, 4'b1000, 1'b1, 1'b0, 4'd4},  // R4 ready passed, next to slave 3
    {2'd1, A3, 4'b1000, 1'b1, 4'b1000, 1'b0, 1'b0, 4'd5},  // R5 captured slave 3 granted
    {2'd1, A3, 4'b1000, 1'b1, 4'b1000, 1'b1, 1'b0, 4'd8},  // R8 BUSY keeps owned request
    {2'd1, A3, 4'b0000, 1'b1, 4'b0000, 1'b1, 1'b0, 4'd9},  // R9 grant lost
    {2'd1, A3, 4'b1000, 1'b1, 4'b0000, 1'b1, 1'b0, 4'd9},  // R9 grant back, still silent
    {2'd3, A3, 4'b1000, 1'b1, 4'b1000, 1'b1, 1'b0, 4'd9},  // R9 SEQ requests again
    {2'd0, A0, 4'b1000, 1'b1, 4'b0000, 1'b1, 1'b0, 4'd2},  // R2 idle after data phase
    {2'd2, H2, 4'b0000, 1'b1, 4'b0000, 1'b1, 1'b0, 4'd7},  // R7 high hole
    {2'd0, A0, 4'b0000, 1'b1, 4'b0000, 1'b0, 1'b1, 4'd7},  // R7 first error cycle
    {2'd0, A0, 4'b0000, 1'b1, 4'b0000, 1'b1, 1'b1, 4'd7},  // R7 second error cycle
    {2'd0, A0, 4'b0000, 1'b1, 4'b0000, 1'b1, 1'b0, 4'd2}   // R2 back to OKAY
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] t, input logic [31:0] a, input logic w,
                       input logic [3:0] g, input logic sh);
    @(negedge clk);
    m_htrans = t; m_haddr = a; m_hwrite = w; s_gnt = g; s_hready = sh;
    #2;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #2;
    chk("R1", "m_hready", 32'(m_hready), 32'd1);
    chk("R1", "m_hresp",  32'(m_hresp),  32'd0);
    chk("R1", "s_req",    32'(s_req),    32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [48:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d row%0d", v[3:0], i);
      drive(v[48:47], v[46:15], 1'b0, v[14:11], v[10]);
      chk(tag, "s_req",    32'(s_req),    32'(v[9:6]));
      chk(tag, "m_hready", 32'(m_hready), 32'(v[5]));
      chk(tag, "m_hresp",  32'(m_hresp),  32'(v[4]));
      chk("R10", "req count", 32'($countones(s_req) <= 1), 32'd1);
    end

    // R5: live path before capture, captured copy afterwards
    drive(2'd2, A2, 1'b1, 4'b0000, 1'b1);
    chk("R5", "bypass addr", s_haddr, A2);
    chk("R5", "bypass req",  32'(s_req), 32'b0100);
    drive(2'd2, A1, 1'b0, 4'b0000, 1'b1);
    chk("R5", "captured addr",  s_haddr, A2);
    chk("R5", "captured write", 32'(s_hwrite), 32'd1);
    chk("R5", "captured req",   32'(s_req), 32'b0100);
    chk("R5", "wait ready",     32'(m_hready), 32'd0);

    // R1: reset in the middle of a wait drops the capture
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_htrans = 2'd0; m_haddr = A0; s_gnt = 4'b0000;
    #2;
    chk("R1", "ready after reset", 32'(m_hready), 32'd1);
    chk("R1", "req after reset",   32'(s_req), 32'd0);
    chk("R1", "addr after reset",  s_haddr, A0);

    // R4: ready follows the slave through the data phase
    drive(2'd2, A0, 1'b0, 4'b0001, 1'b1);
    chk("R3", "slave 0 req", 32'(s_req), 32'b0001);
    drive(2'd0, A0, 1'b0, 4'b0001, 1'b0);
    chk("R4", "ready low", 32'(m_hready), 32'd0);
    drive(2'd0, A0, 1'b0, 4'b0001, 1'b1);
    chk("R4", "ready high", 32'(m_hready), 32'd1);
    drive(2'd0, A0, 1'b0, 4'b0000, 1'b1);
    chk("R2", "idle ready", 32'(m_hready), 32'd1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule